// File: doc/BRIEF.md
# Delay Calibration Code Counter

This block produces the 6-bit select code for one programmable delay element in a self-tuning, levelized logic pipeline. Code zero selects the longest delay and the all-ones code the shortest. During calibration of its level the block raises the code by one per checked cycle, and so shortens the delay step by step. It stops when an external controller removes the level enable, which happens once a timing error is seen. It also stops by itself when the code reaches all ones.

Levels that contain gates with both output polarities are checked on alternating cycles: one polarity on odd cycles and the other on even cycles. A mode input marks such a level. In that mode the code advances only on every second enabled cycle. A phase toggle keeps track of the odd and even cycles, and it moves only on enabled cycles. When tuning of the level ends, the code stays frozen and keeps its delay element at the value it reached.

Top module: `delay_code_counter`

## Requirements
- R1: When rstN is low, code is 0 and overflow is 0, and the odd/even phase returns to its first phase. After reset, the first enabled cycle of a dual-polarity level does not step the code.
- R2: When dualPolarity is 0, levelEn is 1 and overflow is 0, code increases by exactly 1 at each rising clock edge.
- R3: When levelEn is 0, code and overflow keep their values.
- R4: When dualPolarity is 1, code increases only on every second enabled edge. An edge that does not step is followed by one that does, and the reverse.
- R5: The odd/even phase advances only on edges where levelEn is 1. Disabled cycles placed between enabled cycles do not shift the point where the code steps.
- R6: overflow goes to 1 at the same edge where code becomes 63 (all ones, the minimum delay).
- R7: Once set, overflow stays 1 and code stays at 63 until reset. The code never wraps to 0, whatever levelEn and dualPolarity do.
- R8: overflow is 0 whenever code is below 63.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Calibration clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| levelEn | input | 1 | Calibration enable for this level from the external controller |
| dualPolarity | input | 1 | 1 when the level holds dual-polarity gates; the code then steps every second enabled cycle |
| code | output | 6 | Delay select code; a higher value gives a shorter delay |
| overflow | output | 1 | Sticky flag, raised when code reaches all ones |

## Verification
The embedded properties check these rules on every cycle: the code holds while the level is disabled, it steps by one when a step is strobed, dual-polarity steps never come back to back, the phase is frozen on disabled cycles, and overflow is exactly tied to the all-ones code and sticks. Only the bench scenarios can show the exact cycle where the code steps after interleaved disabled cycles and mode changes. They also show that reset returns the phase to its first position, and that a long enabled run climbs through all 64 codes and then saturates without wrapping.

// File: rtl/dly_cal_pkg.sv
package dly_cal_pkg;

  // Strobes from the control path to the code datapath
  typedef struct packed {
    logic step;      // raise the code by one on this edge
    logic lastStep;  // this step lands on the all-ones code
  } calStrobe_t;

endpackage

// File: rtl/dly_cal_ctrl.sv
module dly_cal_ctrl
  import dly_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       levelEn,
  input  logic       dualPolarity,
  input  logic       saturated,
  input  logic       atPenultimate,
  output calStrobe_t strobe
);

  logic phaseQ;
  logic activeCycle;

  // A cycle counts only while enabled and not yet saturated
  assign activeCycle = levelEn && !saturated;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ <= 1'b0;
    end else if (activeCycle) begin
      phaseQ <= !phaseQ;
    end
  end

  always_comb begin
    strobe = '0;
    if (activeCycle) begin
      strobe.step = dualPolarity ? phaseQ : 1'b1;
    end
    strobe.lastStep = strobe.step && atPenultimate;
  end

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !levelEn |=> $stable(phaseQ)); // R5

  AST_DUAL_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && dualPolarity) |=> !(strobe.step && dualPolarity)); // R4

endmodule

// File: rtl/dly_cal_datapath.sv
module dly_cal_datapath
  import dly_cal_pkg::*;
#(
  parameter int CODE_WIDTH = 6
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  calStrobe_t            strobe,
  output logic [CODE_WIDTH-1:0] code,
  output logic                  overflow,
  output logic                  atPenultimate
);

  localparam logic [CODE_WIDTH-1:0] CODE_MAX = '1;
  localparam logic [CODE_WIDTH-1:0] CODE_ONE = CODE_WIDTH'(1);

  logic [CODE_WIDTH-1:0] countQ;
  logic                  ovfQ;

  assign atPenultimate = (countQ == CODE_MAX - CODE_ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
      ovfQ   <= 1'b0;
    end else begin
      if (strobe.step && !ovfQ) begin
        countQ <= countQ + CODE_ONE;
      end
      if (strobe.lastStep) begin
        ovfQ <= 1'b1;
      end
    end
  end

  assign code     = countQ;
  assign overflow = ovfQ;

  AST_STEP_INCREMENT: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !ovfQ) |=> (countQ == $past(countQ) + CODE_ONE)); // R2

  AST_OVERFLOW_AT_MAX: assert property (@(posedge clk) disable iff (!rstN)
    (countQ == CODE_MAX) |-> ovfQ); // R6

  AST_OVERFLOW_ONLY_AT_MAX: assert property (@(posedge clk) disable iff (!rstN)
    ovfQ |-> (countQ == CODE_MAX)); // R8

  AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ovfQ |=> (ovfQ && countQ == CODE_MAX)); // R7

endmodule

// File: rtl/delay_code_counter.sv
module delay_code_counter
  import dly_cal_pkg::*;
#(
  parameter int CODE_WIDTH = 6
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  levelEn,
  input  logic                  dualPolarity,
  output logic [CODE_WIDTH-1:0] code,
  output logic                  overflow
);

  calStrobe_t strobe;
  logic       atPenultimate;

  dly_cal_ctrl ctrl_i (
    .clk           (clk),
    .rstN          (rstN),
    .levelEn       (levelEn),
    .dualPolarity  (dualPolarity),
    .saturated     (overflow),
    .atPenultimate (atPenultimate),
    .strobe        (strobe)
  );

  dly_cal_datapath #(
    .CODE_WIDTH (CODE_WIDTH)
  ) dp_i (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .code          (code),
    .overflow      (overflow),
    .atPenultimate (atPenultimate)
  );

  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    !levelEn |=> ($stable(code) && $stable(overflow))); // R3

endmodule

// File: tb/delay_code_counter_tb_top.sv
module delay_code_counter_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       levelEn = 1'b0;
  logic       dualPolarity = 1'b0;
  logic [5:0] code;
  logic       overflow;

  int checks = 0;
  int fails = 0;

  always #4 clk = !clk;

  delay_code_counter dut_i (
    .clk          (clk),
    .rstN         (rstN),
    .levelEn      (levelEn),
    .dualPolarity (dualPolarity),
    .code         (code),
    .overflow     (overflow)
  );

  // {levelEn, dualPolarity, expected code, expected overflow}
  localparam int NVEC = 14;
  localparam logic [8:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 6'd1, 1'b0},  // R2 step, phase->1
    {1'b1, 1'b0, 6'd2, 1'b0},  // R2 step, phase->0
    {1'b0, 1'b0, 6'd2, 1'b0},  // R3 hold
    {1'b0, 1'b1, 6'd2, 1'b0},  // R3 hold
    {1'b1, 1'b0, 6'd3, 1'b0},  // R2 step, phase->1
    {1'b1, 1'b1, 6'd4, 1'b0},  // R4 phase 1 steps
    {1'b1, 1'b1, 6'd4, 1'b0},  // R4 phase 0 holds
    {1'b0, 1'b1, 6'd4, 1'b0},  // R5 disabled, phase stays 1
    {1'b1, 1'b1, 6'd5, 1'b0},  // R5 step after gap
    {1'b1, 1'b1, 6'd5, 1'b0},  // R4
    {1'b1, 1'b1, 6'd6, 1'b0},  // R4
    {1'b0, 1'b0, 6'd6, 1'b0},  // R3
    {1'b1, 1'b1, 6'd6, 1'b0},  // R4 phase 0 holds
    {1'b1, 1'b0, 6'd7, 1'b0}   // R2 phase 1, single mode step
  };

  task automatic check(input string req, input logic [5:0] gotCode, input logic gotOvf,
                       input logic [5:0] expCode, input logic expOvf);
    checks++;
    if (gotCode !== expCode || gotOvf !== expOvf) begin
      fails++;
      $display("FAIL %s: code=%0d overflow=%0b expected code=%0d overflow=%0b",
               req, gotCode, gotOvf, expCode, expOvf);
    end
  endtask

  task automatic cycle(input logic en, input logic dual);
    @(negedge clk);
    levelEn = en;
    dualPolarity = dual;
    @(posedge clk);
    #2;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    levelEn = 1'b0;
    #1;
    check("R1", code, overflow, 6'd0, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #20000;
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #2;
    check("R1", code, overflow, 6'd0, 1'b0);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      cycle(VEC[i][8], VEC[i][7]);
      check($sformatf("vector %0d R2/R3/R4/R5", i), code, overflow, VEC[i][6:1], VEC[i][0]);
    end

    // Climb to the top in single mode
    doReset();
    for (int i = 1; i <= 62; i++) begin
      cycle(1'b1, 1'b0);
    end
    check("R8", code, overflow, 6'd62, 1'b0);
    cycle(1'b1, 1'b0);
    check("R6", code, overflow, 6'd63, 1'b1);
    for (int i = 0; i < 5; i++) begin
      cycle(1'b1, i[0]);
    end
    check("R7", code, overflow, 6'd63, 1'b1);
    cycle(1'b0, 1'b0);
    check("R7", code, overflow, 6'd63, 1'b1);

    // Leave phase at odd position, then reset: phase must restart
    doReset();
    cycle(1'b1, 1'b0);
    check("R2", code, overflow, 6'd1, 1'b0);
    doReset();
    cycle(1'b1, 1'b1);
    check("R1", code, overflow, 6'd0, 1'b0);
    cycle(1'b1, 1'b1);
    check("R4", code, overflow, 6'd1, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule